// File: doc/BRIEF.md
# Aperture-Based Address Remapper

This block turns the addresses issued by several bus masters into addresses in the space of a target slave. Each master sees a 32-bit space cut into sixteen windows of 256 MB, and the top four address bits pick the window. Every window carries two small fields. The first names the target slave. The second names the window inside that slave's own space that the access lands in. The lower 28 address bits pass through unchanged. If a window has slave code zero, it leads nowhere, and any access to it is flagged as an error with no slave selected.

Software fills in a set of shadow map registers for each master. The fields go in as 4-bit nibbles, eight windows per 32-bit word. None of these writes changes translation. Translation changes only when software writes the master's bit in a shared commit register, which copies that master's shadow map into its live map. Each master has its own request channel with valid/ready. Its result is registered and held under backpressure.

Top module: `aperture_remap`

## Requirements
- R1: The window index is address bits 31:28. The translated address has bits 31:28 set to the window's target-window field and bits 27:0 equal to the request's bits 27:0.
- R2: For a window whose slave field is k (1 to 15), the result gives rsp_sel = k and rsp_sel_oh with only bit k set, and rsp_err is 0.
- R3: A window whose slave field is 0 is unmapped. The result then has rsp_err = 1, rsp_sel = 0 and rsp_sel_oh all zero.
- R4: The map words of master m sit at byte address 16*m. Offset 0x0 holds the slave fields of windows 0-7, 0x4 holds the slave fields of windows 8-15, 0x8 holds the target-window fields of windows 0-7 and 0xC holds the target-window fields of windows 8-15. Window i uses bits 4*(i mod 8)+3 down to 4*(i mod 8).
- R5: Writes to map words do not change translation. A write to the commit register at 0x100 copies the shadow map into the live map of every master m whose data bit m is 1, and leaves all other masters unchanged.
- R6: Reads of a map word return the shadow value last written. The commit register and unused addresses read as zero.
- R7: After reset, all shadow and live maps are zero, so every window is unmapped. rsp_valid is 0 and req_ready is 1.
- R8: A request accepted at a clock edge (req_valid and req_ready both high) shows its result with rsp_valid at that same edge. The result is held unchanged while rsp_ready is low. req_ready is low while a held result has not been taken.
- R9: A request accepted in the same cycle as a commit is translated with the live map from before the commit.
- R10: Each master translates through its own map. Programming and committing one master does not change another master's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | NUM_MASTERS | Per-master request valid |
| req_ready | output | NUM_MASTERS | Per-master request ready |
| req_addr | input | NUM_MASTERS*32 | Per-master request address, master m in slice m |
| rsp_valid | output | NUM_MASTERS | Per-master result valid |
| rsp_ready | input | NUM_MASTERS | Per-master result taken |
| rsp_addr | output | NUM_MASTERS*32 | Translated address per master |
| rsp_sel | output | NUM_MASTERS*4 | Encoded slave select per master |
| rsp_sel_oh | output | NUM_MASTERS*16 | One-hot slave select per master (bit 0 never set) |
| rsp_err | output | NUM_MASTERS | Unmapped-window error per master |

## Verification
On every cycle, the assertions check the following. The live map changes only at a commit, and then takes the shadow value. A held result stays stable under backpressure. The low 28 bits of an accepted address pass through. An error never comes with a slave select, and the one-hot select has at most one bit set. Other behaviour can only be shown by the bench's scenarios. These cover the nibble placement in the map words and readback of the shadow values. They show that translation does not change before a commit, that one master's commit leaves the other master alone, and that a request meeting a commit in the same cycle still sees the old map.

// File: rtl/aprm_pkg.sv
package aprm_pkg;
  localparam int AP_ADDR_W = 32;
  localparam int AP_IDX_W  = 4;
  localparam int NUM_AP    = 1 << AP_IDX_W;
  localparam int FLD_W     = 4;
  localparam int MAP_W     = NUM_AP * FLD_W;
  localparam int NUM_SLV   = 1 << FLD_W;
  localparam int WORD_W    = 32;
  localparam int LOW_W     = AP_ADDR_W - AP_IDX_W;

  typedef struct packed {
    logic [MAP_W-1:0] sel;
    logic [MAP_W-1:0] ofs;
  } apmap_t;

  function automatic logic [FLD_W-1:0] field_of(input logic [MAP_W-1:0] map,
                                                 input logic [AP_IDX_W-1:0] idx);
    return map[idx*FLD_W +: FLD_W];
  endfunction

  function automatic logic [AP_IDX_W-1:0] win_of(input logic [AP_ADDR_W-1:0] addr);
    return addr[AP_ADDR_W-1 -: AP_IDX_W];
  endfunction

  function automatic logic [AP_ADDR_W-1:0] xlate(input logic [AP_ADDR_W-1:0] addr,
                                                 input logic [MAP_W-1:0] ofs_map);
    return {field_of(ofs_map, win_of(addr)), addr[LOW_W-1:0]};
  endfunction

  function automatic logic [NUM_SLV-1:0] slv_onehot(input logic [FLD_W-1:0] sel);
    logic [NUM_SLV-1:0] oh;
    oh = '0;
    if (sel != '0) oh[sel] = 1'b1;
    return oh;
  endfunction
endpackage

// File: rtl/aprm_regfile.sv
module aprm_regfile
  import aprm_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int REG_AW      = 9,
  parameter int UPD_OFS     = 'h100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [WORD_W-1:0]        reg_wdata,
  output logic [WORD_W-1:0]        reg_rdata,
  output apmap_t [NUM_MASTERS-1:0] shadow,
  output logic [NUM_MASTERS-1:0]   commit
);
  localparam int IDX_W = REG_AW - 4;

  logic [IDX_W-1:0] set_idx;
  logic [1:0]       word_idx;
  logic             upd_hit;

  assign set_idx  = reg_addr[REG_AW-1:4];
  assign word_idx = reg_addr[3:2];
  assign upd_hit  = (reg_addr == REG_AW'(UPD_OFS));
  assign commit   = (reg_wr && upd_hit) ? reg_wdata[NUM_MASTERS-1:0] : '0;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_set
    logic set_wr;
    assign set_wr = reg_wr && !upd_hit && (set_idx == IDX_W'(m));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[m] <= '0;
      end else if (set_wr) begin
        case (word_idx)
          2'd0: shadow[m].sel[WORD_W-1:0]     <= reg_wdata;
          2'd1: shadow[m].sel[MAP_W-1:WORD_W] <= reg_wdata;
          2'd2: shadow[m].ofs[WORD_W-1:0]     <= reg_wdata;
          default: shadow[m].ofs[MAP_W-1:WORD_W] <= reg_wdata;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (!upd_hit && set_idx == IDX_W'(m)) begin
        case (word_idx)
          2'd0: reg_rdata = shadow[m].sel[WORD_W-1:0];
          2'd1: reg_rdata = shadow[m].sel[MAP_W-1:WORD_W];
          2'd2: reg_rdata = shadow[m].ofs[WORD_W-1:0];
          default: reg_rdata = shadow[m].ofs[MAP_W-1:WORD_W];
        endcase
      end
    end
  end

  // R6: commit register never returns data
  assert_upd_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hit |-> reg_rdata == '0);
endmodule

// File: rtl/aprm_active_map.sv
module aprm_active_map
  import aprm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   commit,
  input  apmap_t shadow,
  output apmap_t active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else if (commit) active <= shadow;
  end

  assert_live_only_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));
  assert_commit_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active == $past(shadow));
endmodule

// File: rtl/aprm_xlate_stage.sv
module aprm_xlate_stage
  import aprm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  apmap_t               active,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AP_ADDR_W-1:0] req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [AP_ADDR_W-1:0] rsp_addr,
  output logic [FLD_W-1:0]     rsp_sel,
  output logic [NUM_SLV-1:0]   rsp_sel_oh,
  output logic                 rsp_err
);
  logic             accept;
  logic [FLD_W-1:0] hit_sel;

  assign req_ready  = !rsp_valid || rsp_ready;
  assign accept     = req_valid && req_ready;
  assign hit_sel    = field_of(active.sel, win_of(req_addr));
  assign rsp_sel_oh = slv_onehot(rsp_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_sel   <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= xlate(req_addr, active.ofs);
      rsp_sel   <= hit_sel;
      rsp_err   <= (hit_sel == '0);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_low_bits_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0]));
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_sel_oh) && !rsp_sel_oh[0]);
  assert_err_no_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_sel_oh == '0);
  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_err)
                                  && $stable(rsp_sel));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import aprm_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int REG_AW      = 9,
  parameter int UPD_OFS     = 'h100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic [REG_AW-1:0]                reg_addr,
  input  logic [WORD_W-1:0]                reg_wdata,
  output logic [WORD_W-1:0]                reg_rdata,
  input  logic [NUM_MASTERS-1:0]           req_valid,
  output logic [NUM_MASTERS-1:0]           req_ready,
  input  logic [NUM_MASTERS*AP_ADDR_W-1:0] req_addr,
  output logic [NUM_MASTERS-1:0]           rsp_valid,
  input  logic [NUM_MASTERS-1:0]           rsp_ready,
  output logic [NUM_MASTERS*AP_ADDR_W-1:0] rsp_addr,
  output logic [NUM_MASTERS*FLD_W-1:0]     rsp_sel,
  output logic [NUM_MASTERS*NUM_SLV-1:0]   rsp_sel_oh,
  output logic [NUM_MASTERS-1:0]           rsp_err
);
  apmap_t [NUM_MASTERS-1:0] shadow;
  apmap_t [NUM_MASTERS-1:0] active;
  logic   [NUM_MASTERS-1:0] commit;

  aprm_regfile #(
    .NUM_MASTERS(NUM_MASTERS), .REG_AW(REG_AW), .UPD_OFS(UPD_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .shadow(shadow), .commit(commit)
  );

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    aprm_active_map u_live (
      .clk(clk), .rst_n(rst_n), .commit(commit[m]),
      .shadow(shadow[m]), .active(active[m])
    );
    aprm_xlate_stage u_stage (
      .clk(clk), .rst_n(rst_n), .active(active[m]),
      .req_valid(req_valid[m]), .req_ready(req_ready[m]),
      .req_addr(req_addr[m*AP_ADDR_W +: AP_ADDR_W]),
      .rsp_valid(rsp_valid[m]), .rsp_ready(rsp_ready[m]),
      .rsp_addr(rsp_addr[m*AP_ADDR_W +: AP_ADDR_W]),
      .rsp_sel(rsp_sel[m*FLD_W +: FLD_W]),
      .rsp_sel_oh(rsp_sel_oh[m*NUM_SLV +: NUM_SLV]),
      .rsp_err(rsp_err[m])
    );
  end
endmodule

// File: tb/aperture_remap_tb.sv
module aperture_remap_tb;
  localparam int NM = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NM-1:0] req_valid = '0;
  logic [NM-1:0] req_ready;
  logic [NM*32-1:0] req_addr = '0;
  logic [NM-1:0] rsp_valid;
  logic [NM-1:0] rsp_ready = '1;
  logic [NM*32-1:0] rsp_addr;
  logic [NM*4-1:0] rsp_sel;
  logic [NM*16-1:0] rsp_sel_oh;
  logic [NM-1:0] rsp_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] sh_sel [NM][16];
  logic [3:0] sh_ofs [NM][16];
  logic [3:0] lv_sel [NM][16];
  logic [3:0] lv_ofs [NM][16];

  always #4 clk = ~clk;

  aperture_remap #(.NUM_MASTERS(NM)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_sel(rsp_sel),
    .rsp_sel_oh(rsp_sel_oh), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // word w of master m: 0 sel lo, 1 sel hi, 2 ofs lo, 3 ofs hi
  function automatic logic [31:0] word_of(input int m, input int w);
    logic [31:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      int ap = k + ((w % 2) * 8);
      logic [3:0] n = (w < 2) ? sh_sel[m][ap] : sh_ofs[m][ap];
      v = v | (32'(n) << (4 * k));
    end
    return v;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic commit_model(input logic [NM-1:0] bits);
    for (int m = 0; m < NM; m++)
      if (bits[m]) for (int i = 0; i < 16; i++) begin
        lv_sel[m][i] = sh_sel[m][i]; lv_ofs[m][i] = sh_ofs[m][i];
      end
  endtask

  task automatic program_master(input int m);
    for (int w = 0; w < 4; w++) wr(9'(m * 16 + w * 4), word_of(m, w));
  endtask

  task automatic expect_rsp(input int m, input logic [31:0] a, input logic [3:0] s,
                            input logic [3:0] o, input string tag);
    logic [31:0] ea = {o, a[27:0]};
    logic [15:0] eoh = '0;
    for (int k = 1; k < 16; k++) eoh[k] = (k == int'(s));
    chk(rsp_valid[m] === 1'b1, {tag, " valid R8"}, 32'(rsp_valid[m]), 32'd1);
    chk(rsp_addr[m*32 +: 32] === ea, {tag, " addr R1"}, rsp_addr[m*32 +: 32], ea);
    chk(rsp_sel[m*4 +: 4] === s, {tag, " sel R2"}, 32'(rsp_sel[m*4 +: 4]), 32'(s));
    chk(rsp_sel_oh[m*16 +: 16] === eoh, {tag, " onehot R2 R3"}, 32'(rsp_sel_oh[m*16 +: 16]), 32'(eoh));
    chk(rsp_err[m] === (s == 4'd0), {tag, " err R3"}, 32'(rsp_err[m]), 32'(s == 4'd0));
  endtask

  task automatic xact(input int m, input logic [31:0] a, input string tag);
    logic [3:0] s = lv_sel[m][a[31:28]];
    logic [3:0] o = lv_ofs[m][a[31:28]];
    @(negedge clk);
    req_valid[m] = 1'b1; req_addr[m*32 +: 32] = a;
    @(negedge clk);
    req_valid[m] = 1'b0;
    expect_rsp(m, a, s, o, tag);
  endtask

  task automatic t_reset();
    chk(rsp_valid === '0, "reset rsp_valid R7", 32'(rsp_valid), 0);
    chk(req_ready === '1, "reset req_ready R7", 32'(req_ready), 32'h3);
    foreach (reg_addr_list[i]) begin
      reg_addr = reg_addr_list[i]; #1;
      chk(reg_rdata === 32'h0, "reset readback R7 R6", reg_rdata, 0);
    end
    reg_addr = '0;
  endtask
  logic [8:0] reg_addr_list [4] = '{9'h000, 9'h00C, 9'h014, 9'h100};

  task automatic t_unmapped_at_reset();
    xact(0, 32'h8123_4567, "reset map m0 R7");
    xact(1, 32'hF000_0010, "reset map m1 R7");
  endtask

  task automatic t_program_m0();
    sh_sel[0][0] = 4'd3; sh_ofs[0][0] = 4'h0;
    sh_sel[0][1] = 4'd3; sh_ofs[0][1] = 4'h1;
    sh_sel[0][2] = 4'd2; sh_ofs[0][2] = 4'h0;
    for (int i = 8; i < 12; i++) begin sh_sel[0][i] = 4'd1; sh_ofs[0][i] = 4'(i - 8); end
    sh_sel[0][13] = 4'd3; sh_ofs[0][13] = 4'hD;
    sh_sel[0][14] = 4'd5; sh_ofs[0][14] = 4'hE;
    sh_sel[0][15] = 4'd6; sh_ofs[0][15] = 4'h0;
    program_master(0);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); reg_addr = 9'(w * 4); #1;
      chk(reg_rdata === word_of(0, w), "shadow readback R4 R6", reg_rdata, word_of(0, w));
    end
    // explicit nibble position: window 13 lands in bits 23:20 of the upper select word
    reg_addr = 9'h004; #1;
    chk(reg_rdata[23:20] === 4'd3, "window 13 nibble R4", 32'(reg_rdata[23:20]), 3);
    reg_addr = 9'h100; #1;
    chk(reg_rdata === 32'h0, "commit reg reads zero R6", reg_rdata, 0);
    reg_addr = 9'h040; #1;
    chk(reg_rdata === 32'h0, "unused addr reads zero R6", reg_rdata, 0);
    reg_addr = '0;
    xact(0, 32'h9000_0010, "before commit R5");
  endtask

  task automatic t_commit_m0();
    wr(9'h100, 32'h1);
    commit_model(2'b01);
    xact(0, 32'h9ABC_DEF0, "m0 ddr window R1");
    xact(0, 32'h1000_0004, "m0 win1 R2");
    xact(0, 32'hE765_4321, "m0 win14 R2");
    xact(0, 32'h3FFF_FFFF, "m0 unmapped R3");
    xact(0, 32'hF000_0000, "m0 win15 R1");
    xact(1, 32'h0000_0100, "m1 untouched R10");
  endtask

  task automatic t_master1();
    sh_sel[1][0] = 4'd4; sh_ofs[1][0] = 4'h7;
    sh_sel[1][15] = 4'd15; sh_ofs[1][15] = 4'hA;
    program_master(1);
    reg_addr = 9'h01C; #1;
    chk(reg_rdata === word_of(1, 3), "m1 ofs hi readback R4", reg_rdata, word_of(1, 3));
    reg_addr = '0;
    // commit master 1 only, while changing master 0 shadow to prove it stays
    sh_sel[0][2] = 4'd9; wr(9'h000, word_of(0, 0));
    wr(9'h100, 32'h2);
    commit_model(2'b10);
    xact(1, 32'h0123_4567, "m1 win0 R10");
    xact(1, 32'hF00D_0000, "m1 win15 R2");
    xact(0, 32'h2000_0008, "m0 kept old live map R5 R10");
    xact(1, 32'h8000_0000, "m1 unmapped R3");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready[0] = 1'b0;
    req_valid[0] = 1'b1; req_addr[31:0] = 32'h8000_1111;
    @(negedge clk);
    req_addr[31:0] = 32'hE000_2222;
    chk(req_ready[0] === 1'b0, "stall ready low R8", 32'(req_ready[0]), 0);
    expect_rsp(0, 32'h8000_1111, lv_sel[0][8], lv_ofs[0][8], "stall first");
    @(negedge clk); @(negedge clk);
    expect_rsp(0, 32'h8000_1111, lv_sel[0][8], lv_ofs[0][8], "stall held");
    rsp_ready[0] = 1'b1;
    @(negedge clk);
    req_valid[0] = 1'b0;
    expect_rsp(0, 32'hE000_2222, lv_sel[0][14], lv_ofs[0][14], "after stall");
    @(negedge clk);
    chk(rsp_valid[0] === 1'b0, "drained R8", 32'(rsp_valid[0]), 0);
  endtask

  task automatic t_same_cycle();
    logic [3:0] os, oo;
    sh_sel[0][8] = 4'd7; sh_ofs[0][8] = 4'h5;
    program_master(0);
    os = lv_sel[0][8]; oo = lv_ofs[0][8];
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 9'h100; reg_wdata = 32'h1;
    req_valid[0] = 1'b1; req_addr[31:0] = 32'h8000_0004;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; req_valid[0] = 1'b0;
    expect_rsp(0, 32'h8000_0004, os, oo, "same cycle old map R9");
    commit_model(2'b01);
    xact(0, 32'h8000_0004, "after commit new map R9");
  endtask

  initial begin
    for (int m = 0; m < NM; m++) for (int i = 0; i < 16; i++) begin
      sh_sel[m][i] = '0; sh_ofs[m][i] = '0; lv_sel[m][i] = '0; lv_ofs[m][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unmapped_at_reset();
    t_program_m0();
    t_commit_m0();
    t_master1();
    t_backpressure();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule